// File: doc/BRIEF.md
# Dual Calendar Alarm Comparator

This block watches a running calendar time and compares it with two programmable alarm sets. Each alarm set holds six bytes: seconds, minutes, hours, date, month and day of week. Each byte has the same BCD layout as the time byte it is compared with. Bit 7 of each alarm byte is a match-enable bit. There is no year byte, so the year never takes part in a comparison. The time source marks every advance with a one-cycle tick. On that cycle each set is compared with the time, and a set matches when every byte it has enabled equals the current time.

A match always latches a status flag for its set. The flag holds until software pulses the matching clear input. The shared active-low interrupt line works in one of two ways:
- **Level mode:** the line stays asserted while an enabled set's flag is set.
- **Pulse mode:** every enabled match drives the line low for a fixed number of clock cycles, and the line then releases by itself.

A two-bit output-select value gates the interrupt. Only the value 0 lets alarms reach the line. Any other value means the pin is in use for a clock output, and the line stays high.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, both `alarm_flag` bits are 0 and `irq_n` is 1. Every stored alarm byte is 0, so no set can match until it is written.
- R2: A set matches on a cycle where `tick` is 1 if, for every byte whose bit 7 is 1, bits 6:0 of that byte equal bits 6:0 of the time byte. The match sets that set's `alarm_flag` bit on the next clock edge.
  - Time bytes in `now_time`: [7:0] seconds, [15:8] minutes, [23:16] hours, [31:24] date, [39:32] month, [47:40] day of week.
  - Register address: `reg_addr[3]` selects the set (0 or 1). `reg_addr[2:0]` selects the byte, with 0 to 5 in the same order as the time bytes.
- R3: A set in which every byte has bit 7 equal to 0 never matches, whatever the time.
- R4: Comparison happens only on cycles where `tick` is 1. A matching time presented without a tick sets no flag.
- R5: A byte whose bit 7 is 0 does not affect the result, even when its value differs from the time.
- R6: In level mode (`ctl_im` = 0) with `ctl_fsel` = 0, `irq_n` is 0 exactly while some flag is set whose enable is 1. The enable for set 0 is `ctl_al0e` and for set 1 is `ctl_al1e`. A flag stays set until its bit of `flag_clr` is pulsed, and `irq_n` then returns to 1.
- R7: A match in a set whose enable is 0 still sets that set's flag, but it does not drive `irq_n` low.
- R8: When `ctl_fsel` is not 0, `irq_n` is 1. Setting `ctl_fsel` back to 0 restores the alarm output.
- R9: In pulse mode (`ctl_im` = 1) with `ctl_fsel` = 0, every match of an enabled set drives `irq_n` low for exactly PULSE_LEN clock cycles (default 4). The line then returns to 1 without any clear, and the next match pulses it again.
- R10: The two sets are independent. A match in one set sets only its own flag, and `flag_clr` clears only the flags whose bits are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe marking a time advance |
| now_time | input | 48 | Current time, six BCD bytes (order in R2) |
| reg_wr | input | 1 | Alarm byte write strobe |
| reg_addr | input | 4 | Bit 3 selects the set, bits 2:0 select the byte |
| reg_wdata | input | 8 | Alarm byte: bit 7 is the match enable, bits 6:0 are the value |
| ctl_al0e | input | 1 | Interrupt enable for set 0 |
| ctl_al1e | input | 1 | Interrupt enable for set 1 |
| ctl_im | input | 1 | 1 selects pulse mode, 0 selects level mode |
| ctl_fsel | input | 2 | Output select; 0 routes alarms to `irq_n` |
| flag_clr | input | 2 | One-cycle clear strobes, one per flag |
| alarm_flag | output | 2 | Latched match status, one per set |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions assume that `tick` lasts a single cycle per time advance. They also assume that `ctl_im` and `ctl_fsel` are held steady while an interrupt is in progress, so that a pulse-length window is never entered from a level-mode assertion. The stimulus changes the control inputs only while `irq_n` is high and all flags are clear. It gives every tick exactly one cycle, and it presents alarm writes and time values on the falling clock edge.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants and types for the dual calendar alarm comparator.
// Assumes BCD time bytes whose bit 7 is unused by the time source.
package rtc_alarm_pkg;
    localparam int NUM_SETS   = 2;
    localparam int NUM_FIELDS = 6;
    localparam int BYTE_W     = 8;
    localparam int SET_W      = $clog2(NUM_SETS);
    localparam int FLD_W      = $clog2(NUM_FIELDS);
    localparam int ADDR_W     = SET_W + FLD_W;
    localparam int TIME_W     = NUM_FIELDS * BYTE_W;

    // Output-select code that routes alarms to the interrupt pin.
    localparam logic [1:0] FSEL_ALARM = 2'b00;

    typedef logic [BYTE_W-1:0]                 field_t;
    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_set_t;
endpackage

// File: rtl/alarm_regfile.sv
// Alarm byte storage: NUM_SETS sets of NUM_FIELDS bytes, written one byte
// at a time. Assumes the address packs the set index above the byte index.
// Writes to byte indices of NUM_FIELDS or more are dropped.
module alarm_regfile
    import rtc_alarm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  field_t                    wdata,
    output field_set_t [NUM_SETS-1:0] sets
);
    logic [SET_W-1:0] wr_set;
    logic [FLD_W-1:0] wr_fld;

    assign wr_set = addr[ADDR_W-1:FLD_W];
    assign wr_fld = addr[FLD_W-1:0];

    genvar s, f;
    generate
        for (s = 0; s < NUM_SETS; s++) begin : g_set
            for (f = 0; f < NUM_FIELDS; f++) begin : g_fld
                // Hold one alarm byte; clear it on reset, load it on a matching write.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        sets[s][f] <= '0;
                    else if (wr && (wr_set == SET_W'(s)) && (wr_fld == FLD_W'(f)))
                        sets[s][f] <= wdata;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/alarm_compare.sv
// Compares one alarm set with the current time. Bit 7 of each alarm byte
// enables that byte, and bits 6:0 are compared. A set with nothing enabled
// never matches. The result is qualified by the tick. Purely combinational.
module alarm_compare
    import rtc_alarm_pkg::*;
(
    input  logic       tick,
    input  field_set_t alarm,
    input  field_set_t now,
    output logic       hit
);
    logic [NUM_FIELDS-1:0] fld_en;
    logic [NUM_FIELDS-1:0] fld_ok;

    genvar f;
    generate
        for (f = 0; f < NUM_FIELDS; f++) begin : g_fld
            assign fld_en[f] = alarm[f][BYTE_W-1];
            assign fld_ok[f] = !fld_en[f] ||
                               (alarm[f][BYTE_W-2:0] == now[f][BYTE_W-2:0]);
        end
    endgenerate

    // A match needs a tick, at least one enabled byte and every enabled byte equal.
    always_comb hit = tick && (|fld_en) && (&fld_ok);
endmodule

// File: rtl/alarm_irq.sv
// Status flags and interrupt shaping. Flags latch on any match and clear
// on a strobe; a match has priority over a clear in the same cycle.
// Level mode follows the enabled flags. Pulse mode gives a PULSE_LEN-cycle
// low pulse per enabled match. Assumes PULSE_LEN >= 1.
module alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SETS-1:0] hit,
    input  logic [NUM_SETS-1:0] clr,
    input  logic [NUM_SETS-1:0] irq_en,
    input  logic                im,
    input  logic [1:0]          fsel,
    output logic [NUM_SETS-1:0] flag,
    output logic                irq_n
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] pulse_cnt;
    logic             level_act;
    logic             pulse_act;

    // Latch match status per set until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= '0;
        else
            flag <= (flag & ~clr) | hit;
    end

    // Reload the pulse timer on an enabled match in pulse mode, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_cnt <= '0;
        else if (im && |(hit & irq_en))
            pulse_cnt <= CNT_W'(PULSE_LEN);
        else if (pulse_cnt != '0)
            pulse_cnt <= pulse_cnt - 1'b1;
    end

    // Select the interrupt source by mode and gate it with the output select.
    always_comb begin
        level_act = |(flag & irq_en);
        pulse_act = (pulse_cnt != '0);
        irq_n     = !((fsel == FSEL_ALARM) && (im ? pulse_act : level_act));
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Top level of the dual calendar alarm comparator. Stores two alarm sets,
// compares them with the time on each tick and drives the status flags
// and the active-low interrupt. Assumes the tick lasts one cycle per advance.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [TIME_W-1:0]   now_time,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    input  logic                ctl_al0e,
    input  logic                ctl_al1e,
    input  logic                ctl_im,
    input  logic [1:0]          ctl_fsel,
    input  logic [NUM_SETS-1:0] flag_clr,
    output logic [NUM_SETS-1:0] alarm_flag,
    output logic                irq_n
);
    field_set_t [NUM_SETS-1:0] alarm_sets;
    field_set_t                now_fields;
    logic [NUM_SETS-1:0]       set_hit;

    assign now_fields = now_time;

    alarm_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .sets  (alarm_sets)
    );

    genvar s;
    generate
        for (s = 0; s < NUM_SETS; s++) begin : g_cmp
            alarm_compare u_cmp (
                .tick  (tick),
                .alarm (alarm_sets[s]),
                .now   (now_fields),
                .hit   (set_hit[s])
            );
        end
    endgenerate

    alarm_irq #(.PULSE_LEN(PULSE_LEN)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (set_hit),
        .clr    (flag_clr),
        .irq_en ({ctl_al1e, ctl_al0e}),
        .im     (ctl_im),
        .fsel   (ctl_fsel),
        .flag   (alarm_flag),
        .irq_n  (irq_n)
    );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Port-level checker for the dual calendar alarm comparator. Assumes a
// one-cycle tick, and that the mode and output select stay steady while
// the interrupt is low.
module rtc_alarm_match_chk #(
    parameter int PULSE_LEN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       ctl_al0e,
    input logic       ctl_al1e,
    input logic       ctl_im,
    input logic [1:0] ctl_fsel,
    input logic [1:0] flag_clr,
    input logic [1:0] alarm_flag,
    input logic       irq_n
);
    logic [15:0] low_run;

    // Count consecutive low interrupt cycles in pulse mode, restarting on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || tick || irq_n || !ctl_im)
            low_run <= '0;
        else if (low_run != 16'hFFFF)
            low_run <= low_run + 1'b1;
    end

    genvar i;
    generate
        for (i = 0; i < 2; i++) begin : g_flag
            assert_flag_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(alarm_flag[i]) |-> $past(tick));
            assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (alarm_flag[i] && !flag_clr[i]) |=> alarm_flag[i]);
        end
    endgenerate

    assert_fsel_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_fsel != 2'b00) |-> irq_n);

    assert_level_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_im && !irq_n) |-> ((alarm_flag & {ctl_al1e, ctl_al0e}) != 2'b00));

    assert_pulse_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_im |-> (low_run <= 16'(PULSE_LEN)));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ctl_al0e   (ctl_al0e),
    .ctl_al1e   (ctl_al1e),
    .ctl_im     (ctl_im),
    .ctl_fsel   (ctl_fsel),
    .flag_clr   (flag_clr),
    .alarm_flag (alarm_flag),
    .irq_n      (irq_n)
);

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
    localparam int PULSE_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [47:0] now_time = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        ctl_al0e = 1'b0, ctl_al1e = 1'b0, ctl_im = 1'b0;
    logic [1:0]  ctl_fsel = 2'b00;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  alarm_flag;
    logic        irq_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rtc_alarm_match #(.PULSE_LEN(PULSE_LEN)) u_rtc_alarm_match (
        .clk(clk), .rst_n(rst_n), .tick(tick), .now_time(now_time),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ctl_al0e(ctl_al0e), .ctl_al1e(ctl_al1e), .ctl_im(ctl_im),
        .ctl_fsel(ctl_fsel), .flag_clr(flag_clr),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    // Time vectors {dow, month, date, hour, min, sec} plus an expected-match bit.
    // Set 0 holds: sec 0x30 enabled, min 0x15 enabled, hour 0x07 disabled.
    localparam logic [48:0] VECS [6] = '{
        {1'b1, 8'h01, 8'h01, 8'h01, 8'h12, 8'h15, 8'h30},
        {1'b0, 8'h01, 8'h01, 8'h01, 8'h12, 8'h16, 8'h30},
        {1'b0, 8'h01, 8'h01, 8'h01, 8'h12, 8'h15, 8'h31},
        {1'b1, 8'h01, 8'h01, 8'h01, 8'h07, 8'h15, 8'h30},
        {1'b1, 8'h06, 8'h12, 8'h31, 8'h23, 8'h15, 8'h30},
        {1'b0, 8'h03, 8'h05, 8'h09, 8'h07, 8'h15, 8'h29}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Present a time with a one-cycle tick; returns at the negedge after the edge.
    task automatic tick_time(input logic [47:0] t);
        @(negedge clk);
        now_time = t; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 2'b11;
        @(negedge clk);
        flag_clr = 2'b00;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lows;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flags after reset", {6'd0, alarm_flag}, 8'h00);
        check("R1 irq after reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        ctl_al0e = 1'b1; ctl_al1e = 1'b1;
        tick_time(48'h0);
        check("R1 unwritten sets never match", {6'd0, alarm_flag}, 8'h00);

        // Program set 0
        write_byte(4'h0, 8'hB0);
        write_byte(4'h1, 8'h95);
        write_byte(4'h2, 8'h07);

        // R2 / R5: vector table walk in level mode
        for (int v = 0; v < 6; v++) begin
            tick_time(VECS[v][47:0]);
            check($sformatf("R2 R5 vector %0d flag0", v), {7'd0, alarm_flag[0]}, {7'd0, VECS[v][48]});
            check($sformatf("R6 vector %0d irq", v), {7'd0, irq_n}, {7'd0, ~VECS[v][48]});
            clear_flags();
        end

        // R4: matching time but no tick
        @(negedge clk);
        now_time = VECS[0][47:0];
        repeat (3) @(negedge clk);
        check("R4 no tick no flag", {6'd0, alarm_flag}, 8'h00);

        // R3: set 1 holds equal values with every enable bit 0
        write_byte(4'h8, 8'h30);
        write_byte(4'h9, 8'h15);
        tick_time(VECS[0][47:0]);
        check("R3 disabled set no flag1", {7'd0, alarm_flag[1]}, 8'h00);
        check("R2 set0 still matches", {7'd0, alarm_flag[0]}, 8'h01);
        clear_flags();

        // R7: enable off still latches flag but no interrupt
        @(negedge clk); ctl_al0e = 1'b0;
        tick_time(VECS[0][47:0]);
        check("R7 flag with enable off", {7'd0, alarm_flag[0]}, 8'h01);
        check("R7 irq stays high", {7'd0, irq_n}, 8'h01);
        @(negedge clk); ctl_al0e = 1'b1;
        @(negedge clk);
        check("R6 enable on asserts irq", {7'd0, irq_n}, 8'h00);

        // R8: output select masks the interrupt
        ctl_fsel = 2'b01;
        @(negedge clk);
        check("R8 fsel 01 masks irq", {7'd0, irq_n}, 8'h01);
        ctl_fsel = 2'b11;
        @(negedge clk);
        check("R8 fsel 11 masks irq", {7'd0, irq_n}, 8'h01);
        ctl_fsel = 2'b00;
        @(negedge clk);
        check("R8 fsel 00 restores irq", {7'd0, irq_n}, 8'h00);

        // R6: clear releases the line
        clear_flags();
        check("R6 clear flag", {6'd0, alarm_flag}, 8'h00);
        check("R6 clear releases irq", {7'd0, irq_n}, 8'h01);

        // R10: set 1 on day of week 3 only
        write_byte(4'h8, 8'h00);
        write_byte(4'h9, 8'h00);
        write_byte(4'hD, 8'h83);
        tick_time(VECS[5][47:0]);
        check("R10 only set1 flags", {6'd0, alarm_flag}, 8'h02);
        tick_time(VECS[0][47:0]);
        check("R10 both flags", {6'd0, alarm_flag}, 8'h03);
        @(negedge clk); flag_clr = 2'b10;
        @(negedge clk); flag_clr = 2'b00;
        check("R10 clear set1 keeps set0", {6'd0, alarm_flag}, 8'h01);
        clear_flags();

        // R9: pulse mode, two consecutive matches
        @(negedge clk); ctl_im = 1'b1; ctl_al1e = 1'b0;
        for (int p = 0; p < 2; p++) begin
            tick_time(VECS[3][47:0]);
            lows = 0;
            while (irq_n == 1'b0 && lows < 20) begin
                lows++;
                @(negedge clk);
            end
            check($sformatf("R9 pulse %0d length", p), 8'(lows), 8'(PULSE_LEN));
            check($sformatf("R9 pulse %0d released", p), {7'd0, irq_n}, 8'h01);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule